// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial bus (I2C-style) in front of a 2,048-byte array. A fast system clock samples SCL and SDA through two-flop synchronizers. Edge logic turns the synchronized levels into SCL rise, SCL fall, Start and Stop events. A state machine consumes these events to decode a device-address byte and a word-address byte, then either writes data bytes or streams read bytes. Writes are committed the moment each byte completes, so the slave never has a busy period and always acknowledges its address. The open-drain data pin is modelled as an output enable: when the enable is 1 the pad pulls SDA low, and when it is 0 the line is released.

The device-address byte carries a four-bit type code (1010), three page bits and a direction bit. The page bits form address bits 10..8. The word-address byte supplies bits 7..0. A single 11-bit counter serves both directions and advances after every byte, wrapping at the top of the array. A write-protect input keeps every location unchanged, but the bus handshake proceeds as usual.

The states are IDLE, DEV (receiving the device byte), DEV_ACK, WADDR, WADDR_ACK, WDATA, WDATA_ACK, RDATA (shifting a byte out), RACK (sampling the master's response) and IGNORE. A Start from any state goes to DEV, and a Stop from any state goes to IDLE. The remaining transitions all happen on an SCL fall:
- DEV goes to DEV_ACK on a type match and to IGNORE otherwise.
- DEV_ACK goes to RDATA for a read and to WADDR for a write.
- WADDR goes to WADDR_ACK, WADDR_ACK goes to WDATA, and WDATA and WDATA_ACK alternate.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA on an acknowledge and to IGNORE on a no-acknowledge.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, and while no transaction is addressing the block, SDA is released (`sda_oe_o` = 0).
- R2: The first byte after a Start is the device byte. If bits 7..4 equal 1010, the slave drives an acknowledge. Bits 3..1 become address bits 10..8, and bit 0 selects read (1) or write (0).
- R3: A device byte whose bits 7..4 differ from 1010 is not acknowledged. All following bytes are also not acknowledged until the next Start.
- R4: A Start at any point restarts decoding at the device byte. A Stop returns the slave to idle. A byte cut short by either is never stored.
- R5: SDA is sampled on SCL rising edges. The slave changes its SDA drive only while SCL is low, and an acknowledge stays steady through the whole SCL high phase.
- R6: In a write, the byte after the device byte is the word address (bits 7..0). Each following byte is acknowledged and stored at once at the 11-bit address {page, word}.
- R7: The 11-bit address advances by one after every data byte, in both writes and reads, and wraps from 2047 to 0.
- R8: In a read, the slave sends successive bytes for as long as the master acknowledges. A master no-acknowledge ends the read, and the slave releases SDA.
- R9: After an address-only write followed by a repeated Start and a read device byte, reading begins at the latched word address. The page comes from the new device byte.
- R10: While `wp_i` is 1, data bytes are still acknowledged but no location changes.
- R11: Bytes are shifted most significant bit first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| wp_i | input | 1 | Write protect, 1 blocks all stores |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Writes and reads use data patterns that are not bit-palindromes, such as C1 and 5E, so a byte shifted in the wrong bit order shows up as wrong data. Reads are tried in several forms: after a repeated Start with a different page than the one used for the address write, as a four-byte burst crossing two earlier writes, and across the 2047-to-0 boundary. These separate page handling, counter advance and wrap. A protected write followed by a read-back shows whether protection blocks the store while keeping the acknowledge. A wrong type code, a Start part-way through a byte and a Stop part-way through a byte each test a different path back to address decoding.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tw_state_e;

    localparam int unsigned BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_i[g]};
            end
            assign q_o[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tw_cond.sv
module tw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_store.sv
module tw_store #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i,
    input  logic [AW-1:0] ra_i,
    output logic [DW-1:0] rd_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[wa_i] <= wd_i;
        rd_o <= cells[ra_i];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cells[$past(wa_i)] == $past(wd_i))); // R6
endmodule

// File: rtl/tw_fsm.sv
module tw_fsm
    import tw_pkg::*;
#(
    parameter int unsigned AW     = 11,
    parameter int unsigned PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              wp_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_wa_o,
    output logic [BYTE_W-1:0] mem_wd_o,
    output logic [AW-1:0]     mem_ra_o,
    output logic              sda_oe_o
);
    localparam int unsigned WORD_W = AW - PAGE_W;
    localparam int unsigned BCNT_W = $clog2(BYTE_W + 1);
    localparam int unsigned TCNT_W = $clog2(BYTE_W);
    localparam logic [BCNT_W-1:0] FULL_CNT = BCNT_W'(BYTE_W);
    localparam logic [TCNT_W-1:0] LAST_TX  = TCNT_W'(BYTE_W - 1);

    tw_state_e           state, state_nx;
    logic [BYTE_W-1:0]   shreg;
    logic [BCNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]   txreg;
    logic [TCNT_W-1:0]   txcnt;
    logic [AW-1:0]       addr;
    logic                rw_q;
    logic                mnack;
    logic                full;
    logic                type_ok;
    logic                rx_state;

    assign full     = (bitcnt == FULL_CNT);
    assign type_ok  = (shreg[BYTE_W-1 -: 4] == DEV_TYPE);
    assign rx_state = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_DEV;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_DEV:       if (full) state_nx = type_ok ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   state_nx = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (full) state_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: state_nx = ST_WDATA;
                ST_WDATA:     if (full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nx = ST_WDATA;
                ST_RDATA:     if (txcnt == LAST_TX) state_nx = ST_RACK;
                ST_RACK:      state_nx = mnack ? ST_IGNORE : ST_RDATA;
                ST_IGNORE:    state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            txreg  <= '1;
            txcnt  <= '0;
            addr   <= '0;
            rw_q   <= 1'b0;
            mnack  <= 1'b1;
        end else if (start_ev || stop_ev) begin
            bitcnt <= '0;
            txreg  <= '1;
        end else begin
            if (scl_rise && rx_state) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + BCNT_W'(1);
            end
            if (scl_rise && state == ST_RACK) begin
                mnack <= sda_s;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEV: begin
                        if (full) begin
                            bitcnt <= '0;
                            if (type_ok) begin
                                addr[AW-1 -: PAGE_W] <= shreg[PAGE_W:1];
                                rw_q                 <= shreg[0];
                            end
                        end
                    end
                    ST_WADDR: begin
                        if (full) begin
                            bitcnt             <= '0;
                            addr[WORD_W-1:0]   <= shreg[WORD_W-1:0];
                        end
                    end
                    ST_WDATA: begin
                        if (full) begin
                            bitcnt <= '0;
                            addr   <= addr + AW'(1);
                        end
                    end
                    ST_DEV_ACK: begin
                        if (rw_q) begin
                            txreg <= rd_data_i;
                            txcnt <= '0;
                            addr  <= addr + AW'(1);
                        end
                    end
                    ST_RACK: begin
                        if (!mnack) begin
                            txreg <= rd_data_i;
                            txcnt <= '0;
                            addr  <= addr + AW'(1);
                        end
                    end
                    ST_RDATA: begin
                        if (txcnt != LAST_TX) begin
                            txreg <= {txreg[BYTE_W-2:0], 1'b1};
                            txcnt <= txcnt + TCNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                               sda_oe_o = ~txreg[BYTE_W-1];
            default:                                sda_oe_o = 1'b0;
        endcase
        mem_we_o = (state == ST_WDATA) && scl_fall && full && !wp_i
                   && !start_ev && !stop_ev;
        mem_wa_o = addr;
        mem_wd_o = shreg;
        mem_ra_o = addr;
    end

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_DEV)); // R4
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE)); // R4
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n || start_ev || stop_ev)
        !$stable(sda_oe_o) |-> !scl_s); // R5
    AST_ADDR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && scl_fall && full && type_ok && !start_ev && !stop_ev) |=> sda_oe_o); // R2
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int unsigned AW          = 11,
    parameter int unsigned PAGE_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic              mem_we;
    logic [AW-1:0]     mem_wa, mem_ra;
    logic [BYTE_W-1:0] mem_wd, mem_rd;

    tw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    tw_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tw_fsm #(.AW(AW), .PAGE_W(PAGE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .wp_i      (wp_i),
        .rd_data_i (mem_rd),
        .mem_we_o  (mem_we),
        .mem_wa_o  (mem_wa),
        .mem_wd_o  (mem_wd),
        .mem_ra_o  (mem_ra),
        .sda_oe_o  (sda_oe_o)
    );

    tw_store #(.AW(AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (mem_we),
        .wa_i  (mem_wa),
        .wd_i  (mem_wd),
        .ra_i  (mem_ra),
        .rd_o  (mem_rd)
    );
endmodule

// File: tb/tw_mem_slave_test.sv
module tw_mem_slave_test;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    tw_mem_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [2048];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(g == e, t, g, e);
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0;   m_sda = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic ack, o1, o2;
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(1);
        o1 = sda_oe;  tick(Q);
        ack = ~sda_line;
        o2 = sda_oe;  tick(Q - 1);
        scl = 1'b0;   tick(Q);
        check(ack == exp_ack, req, ack, exp_ack);
        if (exp_ack) check(o1 == o2, "R5", o2, o1);
    endtask

    task automatic read_byte(input bit give_ack);
        logic [7:0] v = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            v = {v[6:0], sda_line}; tick(Q);
            scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
        m_sda = 1'b1;
        got_q.push_back(v);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] pg, input logic rd);
        return {4'b1010, pg, rd};
    endfunction

    task automatic write_seq(input logic [2:0] pg, input logic [7:0] wd,
                             input logic [7:0] d0, input logic [7:0] d1, input string req);
        logic [10:0] a;
        a = {pg, wd};
        bus_start();
        send_byte(dev(pg, 1'b0), 1'b1, "R2");
        send_byte(wd, 1'b1, "R6");
        send_byte(d0, 1'b1, req);
        send_byte(d1, 1'b1, req);
        bus_stop();
        if (!wp) begin
            ref_mem[a]         = d0;
            ref_mem[a + 11'd1] = d1;
        end
    endtask

    task automatic read_seq(input logic [2:0] pg_set, input logic [7:0] wd,
                            input logic [2:0] pg_rd, input int n, input string req);
        logic [10:0] a;
        bus_start();
        send_byte(dev(pg_set, 1'b0), 1'b1, "R2");
        send_byte(wd, 1'b1, "R6");
        bus_start();
        send_byte(dev(pg_rd, 1'b1), 1'b1, "R2");
        for (int i = 0; i < n; i++) begin
            a = {pg_rd, wd} + 11'(i);
            exp_q.push_back(ref_mem[a]);
            tag_q.push_back(req);
            read_byte(i != n - 1);
        end
        check(sda_oe == 1'b0, "R8", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        tick(5);
        check(sda_oe == 1'b0, "R1", sda_oe, 0);
        rst_n = 1'b1;
        tick(10);
        check(sda_oe == 1'b0, "R1", sda_oe, 0);

        // R6 / R11: store two non-palindromic bytes on page 2
        write_seq(3'd2, 8'h10, 8'hC1, 8'h5E, "R6");
        // R9: address latched under page 5, read issued with page 2
        read_seq(3'd5, 8'h10, 3'd2, 2, "R9");
        // R8: four-byte burst spanning two writes
        write_seq(3'd2, 8'h12, 8'hF0, 8'h0F, "R11");
        read_seq(3'd2, 8'h10, 3'd2, 4, "R8");
        // R7: wrap from 2047 to 0 in write and in read
        write_seq(3'd7, 8'hFF, 8'h11, 8'h22, "R7");
        read_seq(3'd0, 8'h00, 3'd0, 1, "R7");
        read_seq(3'd7, 8'hFF, 3'd7, 2, "R7");
        // R10: protected write is acknowledged but not stored
        wp = 1'b1;
        write_seq(3'd2, 8'h10, 8'h00, 8'h00, "R10");
        wp = 1'b0;
        read_seq(3'd2, 8'h10, 3'd2, 2, "R10");
        // R3: wrong type code, then no ack for following bytes
        bus_start();
        send_byte(8'h94, 1'b0, "R3");
        send_byte(8'h10, 1'b0, "R3");
        bus_stop();
        check(sda_oe == 1'b0, "R3", sda_oe, 0);
        // R4: Start and Stop part-way through a data byte store nothing
        write_seq(3'd0, 8'h40, 8'h77, 8'h88, "R4");
        bus_start();
        send_byte(dev(3'd0, 1'b0), 1'b1, "R2");
        send_byte(8'h41, 1'b1, "R6");
        send_bits(8'h00, 4);
        bus_start();
        send_byte(dev(3'd0, 1'b0), 1'b1, "R4");
        send_byte(8'h40, 1'b1, "R4");
        send_bits(8'hFF, 3);
        bus_stop();
        check(sda_oe == 1'b0, "R4", sda_oe, 0);
        read_seq(3'd0, 8'h40, 3'd0, 2, "R4");

        tick(20);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule